// File: doc/BRIEF.md
# Bus Interrupt Request Generator

This block is a single byte-wide, memory-mapped register that lets software raise one of seven prioritized bus interrupt-request lines. The low three bits of the register hold a request level. Level 0 drives no line. Level n, from 1 to 7, drives request line n and no other line.

The request withdraws itself when the bus interrupt-acknowledge cycle addressed to this module completes. That cycle is signalled to the block by a one-cycle acknowledge pulse. Software can also withdraw the request at any time by writing 0. The five upper register bits are not storage: they always read back as a fixed marker pattern.

The request outputs come from flip-flops, so every change shows up on the lines one clock after the write or acknowledge that caused it. The acknowledge daisy chain and the vector response belong to other logic.

Top module: `irq_request_gen`

## Requirements
- R1: After reset the level field is 000, all seven request lines are low, and the read data is 8'hF0.
- R2: While the level field is 000, none of the request lines is high.
- R3: While the level field holds n (1 to 7), request line n (output bit n-1 of `irq_o`) is high and every other line is low.
- R4: A write loads `wdata[2:0]` into the level field. The new level appears on `rdata` and on `irq_o` right after the clock edge on which `wr_en` is sampled high.
- R5: An acknowledge pulse sampled while the level is nonzero and no write is present clears the level to 000, and all lines are low after that edge.
- R6: Writing 0 withdraws a previously raised request on the next edge.
- R7: When a write and an acknowledge are sampled on the same edge, the written value is loaded and the acknowledge is dropped.
- R8: An acknowledge sampled while the level is 000 changes neither the lines nor the read data.
- R9: `rdata[7:3]` always reads 5'b11110, and writes to `wdata[7:3]` have no effect on the lines or on the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wdata | input | 8 | Write data; only bits 2:0 are stored |
| rdata | output | 8 | Read data: marker 11110 in bits 7:3, level in bits 2:0 |
| iack | input | 1 | One-cycle pulse marking a completed acknowledge for this module |
| irq_o | output | 7 | Active-high request lines; bit k drives line k+1 |

## Verification
Every result of this block is due exactly one edge after the stimulus that causes it. A write, an acknowledge, a write that meets an acknowledge, and a reset each update both `rdata` and `irq_o` on the next rising edge, and nothing takes longer.

The bench drives its inputs on the falling edge. A behavioural model updates on the rising edge from those same inputs. Both outputs are compared with the model on the following falling edge, so each check sees the result in the cycle it is due and never a cycle early. Because the comparison runs on every clock, a value that changes late or that drifts between stimuli is also reported.

// File: rtl/irq_request_gen.sv
module irq_request_gen #(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-LVL_W-1:0] MARKER = 5'b11110,
  localparam int LINES = (1 << LVL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              iack,
  output logic [LINES-1:0]  irq_o
);

  logic [LVL_W-1:0] level_q;
  logic [LVL_W-1:0] level_d;
  logic [LINES-1:0] irq_q;

  always_comb begin
    level_d = level_q;
    if (wr_en)
      level_d = wdata[LVL_W-1:0];
    else if (iack)
      level_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  for (genvar k = 0; k < LINES; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[k] <= 1'b0;
      else        irq_q[k] <= (level_d == LVL_W'(k + 1));
    end
  end

  assign irq_o = irq_q;
  assign rdata = {MARKER, level_q};

endmodule

module irq_request_gen_chk #(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-LVL_W-1:0] MARKER = 5'b11110,
  localparam int LINES = (1 << LVL_W) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              iack,
  input logic [LINES-1:0]  irq_o
);

  a_r2_zero_none: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[LVL_W-1:0] == '0) |-> (irq_o == '0));

  a_r3_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  a_r3_right_line: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[LVL_W-1:0] != '0) |-> irq_o[rdata[LVL_W-1:0] - 1'b1]);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !wr_en && rdata[LVL_W-1:0] != '0) |=> (rdata[LVL_W-1:0] == '0 && irq_o == '0));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[LVL_W-1:0] == $past(wdata[LVL_W-1:0])));

  a_r8_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !wr_en && rdata[LVL_W-1:0] == '0) |=> ($stable(irq_o) && $stable(rdata)));

  a_r9_marker: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:LVL_W] == MARKER);

endmodule

bind irq_request_gen irq_request_gen_chk #(
  .LVL_W(LVL_W), .DATA_W(DATA_W), .MARKER(MARKER)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .iack(iack), .irq_o(irq_o)
);

// File: tb/test_irq_request_gen.sv
module test_irq_request_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       iack = 1'b0;
  logic [7:0] rdata;
  logic [6:0] irq_o;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int model_lvl = 0;
  bit done = 0;
  string req = "R1";

  always #2ns clk = ~clk;

  irq_request_gen i_irq_request_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .iack(iack), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n)      model_lvl <= 0;
    else if (wr_en)  model_lvl <= int'(wdata[2:0]);
    else if (iack)   model_lvl <= 0;
  end

  function automatic logic [6:0] exp_lines(int lvl);
    return (lvl == 0) ? 7'd0 : 7'(1 << (lvl - 1));
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] er;
      logic [6:0] ei;
      er = {5'b11110, 3'(model_lvl)};
      ei = exp_lines(model_lvl);
      vectors++;
      if (rdata !== er || irq_o !== ei) begin
        fails++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", req, rdata, irq_o, er, ei);
      end
    end
  end

  task automatic step(input bit w, input logic [7:0] d, input bit a);
    wr_en = w; wdata = d; iack = a;
    @(negedge clk);
    wr_en = 0; iack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    vectors++;
    if (rdata !== 8'hF0 || irq_o !== 7'd0) begin
      fails++;
      $display("FAIL R1: rdata=%h irq=%b expected rdata=f0 irq=0000000", rdata, irq_o);
    end
    @(negedge clk);
    req = "R4/R3";
    for (int n = 1; n < 8; n++) begin
      step(1, 8'(n), 0);
      step(0, 8'h00, 0);
    end
    req = "R2/R6";
    step(1, 8'h00, 0);
    step(0, 8'h00, 0);
    req = "R8";
    step(0, 8'h00, 1);
    step(0, 8'h00, 0);
    req = "R5";
    for (int n = 1; n < 8; n += 3) begin
      step(1, 8'(n), 0);
      step(0, 8'h00, 1);
      step(0, 8'h00, 0);
    end
    req = "R7";
    step(1, 8'h04, 0);
    step(1, 8'h06, 1);
    step(0, 8'h00, 0);
    step(1, 8'h00, 1);
    step(0, 8'h00, 0);
    req = "R9";
    step(1, 8'hFB, 0);
    step(1, 8'h08, 0);
    step(1, 8'h2D, 0);
    step(0, 8'h00, 0);
    req = "R6";
    step(1, 8'h07, 0);
    step(1, 8'h00, 0);
    step(0, 8'h00, 0);
    req = "R1";
    rst_n = 1'b0;
    step(1, 8'h05, 0);
    rst_n = 1'b1;
    step(0, 8'h00, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!done) begin
      fails++;
      done = 1;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule